// File: doc/BRIEF.md
# Instruction cache invalidation sequencer

This block clears every line of an instruction cache's tag store whenever an invalidation is requested, for example after a FENCE.I or straight out of reset. Before each sweep it asks a key provider for a fresh scrambling key. It starts clearing lines only once that key is reported valid, so that a key change always goes with a full clear of the stored lines.

The control is a four-state machine: idle, waiting for a key, sweeping, and done. During the sweep it drives a tag-write enable and a line index, one line per cycle, from the first line to the last. If a new request arrives while work is in progress, including in the last sweep cycle, the block drops the current sweep, asks for another key and starts again from line zero. A busy flag blocks cache lookups for the whole operation, and a one-cycle done pulse marks the end.

Top module: `icache_inval_ctrl`

## Requirements
- R1: When reset is released, an invalidation starts by itself: in the first cycle after reset, busy and the key request are high, and the tag-write enable and done are low.
- R2: The key request is high only while the block waits for a key. The sweep starts in the cycle after key-valid is seen together with the key request. A key-valid pulse while the block is idle is ignored: no tag write follows and busy stays low.
- R3: A sweep writes the line indices 0, 1, …, NUM_LINES-1, one per cycle, in ascending order, with the tag-write enable high.
- R4: The cycle after the write of index NUM_LINES-1 carries a one-cycle done pulse with no tag write. In the following cycle busy is low.
- R5: A request seen during a sweep, including in the cycle that writes the last index, makes the next cycle a key-request cycle with no tag write and no done. A full sweep from index 0 follows the next key.
- R6: If key-valid never arrives, the block writes no tags, produces no done pulse, and keeps busy and the key request high.
- R7: Busy stays high from the cycle after a request up to and including the done cycle. The lookup grant equals the lookup request while busy is low, and is 0 while busy is high.
- R8: A request while idle, or in the done cycle, makes the key request and busy high in the next cycle.
- R9: A request while the block already waits for a key is absorbed. Exactly one sweep and one done pulse follow the key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| inval_req_i | input | 1 | Invalidation request, one cycle or longer |
| key_valid_i | input | 1 | Key provider reports a fresh key |
| key_req_o | output | 1 | Request for a new scrambling key |
| tag_we_o | output | 1 | Tag-store write enable that clears a line's valid bit |
| tag_idx_o | output | IDX_W | Line index being cleared |
| busy_o | output | 1 | Invalidation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| lookup_req_i | input | 1 | Lookup request from the fetch path |
| lookup_gnt_o | output | 1 | Lookup allowed |

## Verification
A plain sweep after an idle request sets the baseline order of tag writes and the done pulse. Interrupting requests at a middle index and at the last index show whether a restart gets a new key and starts again from zero, not resuming or finishing. Requests in the done cycle and during the key wait separate "restart" from "absorb". A missing key and a stray key-valid while idle show that no sweep can run without the handshake.

// File: rtl/icache_inval_ctrl.sv
module icache_inval_ctrl #(
  parameter int unsigned NUM_LINES = 64,
  localparam int unsigned IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inval_req_i,
  input  logic             key_valid_i,
  output logic             key_req_o,
  output logic             tag_we_o,
  output logic [IDX_W-1:0] tag_idx_o,
  output logic             busy_o,
  output logic             done_o,
  input  logic             lookup_req_i,
  output logic             lookup_gnt_o
);

  typedef enum logic [1:0] {ST_IDLE, ST_KEY, ST_SWEEP, ST_DONE} st_e;

  localparam logic [IDX_W-1:0] LastIdx = IDX_W'(NUM_LINES - 1);

  st_e              state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    unique case (state_q)
      ST_IDLE:  if (inval_req_i) state_d = ST_KEY;
      ST_KEY: begin
        if (key_valid_i) begin
          state_d = ST_SWEEP;
          idx_d   = '0;
        end
      end
      ST_SWEEP: begin
        if (inval_req_i) begin
          state_d = ST_KEY;
        end else if (idx_q == LastIdx) begin
          state_d = ST_DONE;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      ST_DONE:  state_d = inval_req_i ? ST_KEY : ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_KEY;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  assign key_req_o    = (state_q == ST_KEY);
  assign tag_we_o     = (state_q == ST_SWEEP);
  assign tag_idx_o    = idx_q;
  assign done_o       = (state_q == ST_DONE);
  assign busy_o       = (state_q != ST_IDLE);
  assign lookup_gnt_o = lookup_req_i & ~busy_o;

  // R2
  sweep_needs_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tag_we_o) |-> $past(key_req_o && key_valid_i));

  // R3
  sweep_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tag_we_o && $past(tag_we_o)) |-> (tag_idx_o == IDX_W'($past(tag_idx_o) + 1'b1)));

  // R3
  sweep_start_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tag_we_o) |-> (tag_idx_o == '0));

  // R4
  done_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(tag_we_o && tag_idx_o == LastIdx && !inval_req_i));

  // R4
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R5
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tag_we_o && inval_req_i) |=> (key_req_o && !tag_we_o && !done_o));

  // R7
  busy_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(done_o));

  // R8
  idle_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && inval_req_i) |=> (key_req_o && busy_o));

endmodule

// File: tb/tb_icache_inval_ctrl.sv
module tb_icache_inval_ctrl;
  localparam int unsigned N = 8;
  localparam int unsigned W = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inval_req = 1'b0, key_valid = 1'b0, lookup_req = 1'b1;
  logic key_req, tag_we, busy, done, lookup_gnt;
  logic [W-1:0] tag_idx;

  int checks = 0, fails = 0, cyc = 0;
  logic mon_en = 1'b0;
  logic [W:0] expq[$];

  always #5 clk = ~clk;

  icache_inval_ctrl #(.NUM_LINES(N)) dut (
    .clk_i(clk), .rst_ni(rst_n), .inval_req_i(inval_req), .key_valid_i(key_valid),
    .key_req_o(key_req), .tag_we_o(tag_we), .tag_idx_o(tag_idx), .busy_o(busy),
    .done_o(done), .lookup_req_i(lookup_req), .lookup_gnt_o(lookup_gnt)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_sweep(input int upto, input bit with_done);
    for (int i = 0; i <= upto; i++) expq.push_back({1'b0, W'(i)});
    if (with_done) expq.push_back({1'b1, {W{1'b0}}});
  endtask

  // Monitor: pops expected tag writes and done pulses as they appear
  initial forever begin
    @(negedge clk);
    if (mon_en && (tag_we || done)) begin
      logic [W:0] obs;
      obs = tag_we ? {1'b0, tag_idx} : {1'b1, {W{1'b0}}};
      if (tag_we && done) chk("R4 done with write", 1, 0);
      if (expq.size() == 0) chk(done ? "R4 unexpected done" : "R3 unexpected write", 32'(obs), 32'h1ff);
      else chk(done ? "R4 done order" : "R3 write order", 32'(obs), 32'(expq.pop_front()));
    end
  end

  task automatic give_key();
    @(negedge clk); key_valid = 1'b1;
    @(negedge clk); key_valid = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (done) break;
    end
  endtask

  task automatic wait_idx(input int k);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (tag_we && tag_idx == W'(k)) break;
    end
  endtask

  task automatic pulse_req();
    inval_req = 1'b1;
    @(negedge clk); inval_req = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 20000) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected=<20000", cyc);
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1; mon_en = 1'b1;
    @(negedge clk);
    // R1 auto-invalidation out of reset
    chk("R1 busy", busy, 1); chk("R1 key_req", key_req, 1);
    chk("R1 tag_we", tag_we, 0); chk("R1 done", done, 0);
    chk("R7 gnt while busy", lookup_gnt, 0);

    // R6 no key: nothing happens
    repeat (20) @(negedge clk);
    chk("R6 busy held", busy, 1); chk("R6 key_req held", key_req, 1);
    chk("R6 no writes", tag_we, 0);

    // R9 request while waiting for key is absorbed
    pulse_req();
    chk("R9 still waiting", key_req, 1);
    push_sweep(N-1, 1);
    give_key();
    wait_done();
    chk("R7 busy in done", busy, 1);
    @(negedge clk);
    chk("R4 idle after done", busy, 0);
    chk("R7 gnt idle", lookup_gnt, 1);
    lookup_req = 1'b0; #1;
    chk("R7 gnt follows req", lookup_gnt, 0);
    lookup_req = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 single sweep", 32'(expq.size()), 0);

    // R2 stray key-valid while idle is ignored
    key_valid = 1'b1; @(negedge clk); key_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 idle key ignored busy", busy, 0);
    chk("R2 idle no key_req", key_req, 0);

    // R8 idle request
    pulse_req();
    chk("R8 key_req after idle req", key_req, 1);
    chk("R8 busy after idle req", busy, 1);
    // R5 restart mid-sweep
    push_sweep(3, 0);
    push_sweep(N-1, 1);
    give_key();
    wait_idx(3);
    pulse_req();
    chk("R5 key_req after mid restart", key_req, 1);
    chk("R5 no write after mid restart", tag_we, 0);
    give_key();
    wait_done();
    @(negedge clk);
    chk("R5 mid queue drained", 32'(expq.size()), 0);

    // R5 restart in the final sweep cycle
    pulse_req();
    push_sweep(N-1, 0);
    push_sweep(N-1, 1);
    give_key();
    wait_idx(N-1);
    pulse_req();
    chk("R5 key_req after last-cycle restart", key_req, 1);
    chk("R5 no done after last-cycle restart", done, 0);
    give_key();
    wait_done();
    @(negedge clk);
    chk("R5 last queue drained", 32'(expq.size()), 0);

    // R8 request in the done cycle
    pulse_req();
    push_sweep(N-1, 1);
    push_sweep(N-1, 1);
    give_key();
    wait_done();
    pulse_req();
    chk("R8 key_req after done-cycle req", key_req, 1);
    chk("R8 busy after done-cycle req", busy, 1);
    give_key();
    wait_done();
    @(negedge clk);
    chk("R8 idle at end", busy, 0);
    chk("R8 queue drained", 32'(expq.size()), 0);

    finish_run();
  end
endmodule